// File: doc/BRIEF.md
# NAND Operation Sequencer

This block runs one raw NAND bus operation, described by a single 32-bit control word. Flag bits in the word choose which phases take part: a first command cycle, one to eight address cycles, a short data transfer of up to four bytes in either direction, and a second command cycle. The second command can be placed before or after the data. A final wait for the device's ready line can also be requested. Opcodes, address bytes and write data come from companion inputs, which are captured when the operation starts.

Every bus cycle uses the same strobe shape. The strobe is held low for `tLow` clocks and then high for `tHigh` clocks. Both counts come from a separate timing block, and a value of zero counts as one clock. When the last phase finishes, the block raises a one-clock done pulse and sets a sticky done flag. Software clears the flag by writing a one to it.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, every chip enable is high, both strobes are high, CLE and ALE are low, the data bus is not driven, and `busy` and `doneFlag` are 0.
- R2: A control write starts an operation when bit 31 is set and the block is idle. The phases then run in this fixed order, and each one runs only when it is enabled: first command (bit 30), address (bit 29), second command placed early (bit 25 set, bit 24 clear), data (bit 27 for write or bit 26 for read, with write taking precedence), second command placed late (bits 25 and 24 set), and ready wait (bit 16).
- R3: An address phase issues bits 3:0 plus one bytes, limited to 8, with ALE high and CLE low. The bytes go out least significant first: bytes 0 to 3 come from `addrLo` and bytes 4 to 7 come from `addrHi`.
- R4: A command cycle drives CLE high. The first command sends `opcode1` and the second command sends `opcode2`.
- R5: A write data phase sends bits 23:20 plus one bytes, limited to 4. Byte i is `wrData[8i+7:8i]`. The byte stays stable on a driven bus for the whole low time of the write strobe and through its rising edge.
- R6: A read data phase pulses the read strobe with the bus undriven. It samples `nandDqIn` on the rising edge of the strobe and packs byte i into `rdData[8i+7:8i]`. Bytes that are not transferred read as zero.
- R7: When the ready wait is enabled, the operation does not finish until `nandRdy` is sampled high. Completion comes on the clock edge that samples it high.
- R8: For the whole operation, `nandCeN` is the inverse of control bits 15:8, so chip x is selected by bit 8+x. It stays stable while busy and returns to all-ones when idle.
- R9: Completion gives a `donePulse` exactly one clock wide and sets `doneFlag`. A `doneClr` pulse clears the flag, but a completion in the same clock wins over the clear.
- R10: The block ignores a control write whose bit 31 is clear, and a control write that arrives while an operation is running. Changes to the opcode, address and data inputs after the start have no effect.
- R11: Each write or read strobe stays low for `tLow` clocks, with 0 treated as 1. It then stays high for `tHigh` clocks, again with 0 treated as 1, before the next cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Packed operation control word |
| ctrlWrite | input | 1 | Write strobe for the control word |
| doneClr | input | 1 | Write-one-to-clear for the done flag |
| opcode1 | input | 8 | First command opcode |
| opcode2 | input | 8 | Second command opcode |
| addrLo | input | 32 | Address bytes 0 to 3 |
| addrHi | input | 32 | Address bytes 4 to 7 |
| wrData | input | 32 | Write data, first byte in bits 7:0 |
| tLow | input | 4 | Strobe low width in clocks |
| tHigh | input | 4 | Strobe high width in clocks |
| nandDqIn | input | 8 | Data bus from the device |
| nandRdy | input | 1 | Device ready, high when idle |
| rdData | output | 32 | Read data, first byte in bits 7:0 |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-clock completion pulse |
| doneFlag | output | 1 | Sticky completion flag |
| nandCeN | output | 8 | Active-low chip enables |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| nandDqOut | output | 8 | Data bus to the device |
| nandDqOe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach from the ports is a second control write that lands in the middle of a running operation. The same operation also tests that opcode inputs changed after the start are ignored. The stimulus re-pulses the control write a few clocks into a program-style operation, with a different chip select and a different first opcode. It then checks that the bus trace and the chip enables still match the original word. Timing of the ready wait is reached by holding `nandRdy` low until long after the last bus cycle. The bench then confirms that completion lands exactly on the edge that sees it high.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int ADDR_BYTES_MAX = 8;
  localparam int IDX_W          = $clog2(ADDR_BYTES_MAX);

  // control word bit positions
  localparam int CW_GO      = 31;
  localparam int CW_CMD1    = 30;
  localparam int CW_ADDR    = 29;
  localparam int CW_WR      = 27;
  localparam int CW_RD      = 26;
  localparam int CW_CMD2    = 25;
  localparam int CW_LATE    = 24;
  localparam int CW_DLEN    = 20;
  localparam int CW_WAIT    = 16;
  localparam int CW_CE      = 8;
  localparam int CW_ALEN    = 0;
  localparam int LEN_W      = 4;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CMD1     = 3'd1,
    PH_ADDR     = 3'd2,
    PH_CMD2PRE  = 3'd3,
    PH_DATA     = 3'd4,
    PH_CMD2POST = 3'd5,
    PH_WAIT     = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    BK_NONE, BK_CMD1, BK_CMD2, BK_ADDR, BK_WDATA, BK_RDATA
  } busKind_e;

  typedef struct packed {
    logic             load;
    logic             clrRead;
    logic             capture;
    busKind_e         kind;
    logic [IDX_W-1:0] byteIdx;
  } seqStrobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int TIM_W  = 4,
  parameter int CE_NUM = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic              ctrlWrite,
  input  logic              doneClr,
  input  logic [TIM_W-1:0]  tLow,
  input  logic [TIM_W-1:0]  tHigh,
  input  logic              nandRdy,
  output seqStrobe_t        strb,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [CE_NUM-1:0] ceN,
  output logic              busy,
  output logic              donePulse,
  output logic              doneFlag
);

  localparam int DATA_BYTES = DATA_W / 8;

  phase_e             phase, phNext;
  logic               lowPart, lowNext;
  logic [TIM_W-1:0]   tmr, tmrNext, lowLoad, highLoad;
  logic [IDX_W-1:0]   idx, idxNext, addrLast, dataLast, curLast;
  logic [31:0]        cw;
  logic [CE_NUM-1:0]  ceMask;
  logic               startOk, finish, capture, isRead, inBus;

  // lowest enabled phase strictly after the current one
  function automatic phase_e nextPhase(input phase_e cur, input logic [31:0] w);
    logic [6:0] en;
    phase_e     res;
    en          = '0;
    en[1]       = w[CW_CMD1];
    en[2]       = w[CW_ADDR];
    en[3]       = w[CW_CMD2] & ~w[CW_LATE];
    en[4]       = w[CW_WR] | w[CW_RD];
    en[5]       = w[CW_CMD2] & w[CW_LATE];
    en[6]       = w[CW_WAIT];
    res         = PH_IDLE;
    for (int i = 6; i >= 1; i--) begin
      if (en[i] && (i > int'(cur))) res = phase_e'(3'(i));
    end
    return res;
  endfunction

  assign startOk  = ctrlWrite && ctrlWord[CW_GO] && (phase == PH_IDLE);
  assign lowLoad  = (tLow  == '0) ? '0 : tLow  - 1'b1;
  assign highLoad = (tHigh == '0) ? '0 : tHigh - 1'b1;

  assign addrLast = (cw[CW_ALEN +: LEN_W] >= LEN_W'(ADDR_BYTES_MAX - 1)) ?
                    IDX_W'(ADDR_BYTES_MAX - 1) : IDX_W'(cw[CW_ALEN +: LEN_W]);
  assign dataLast = (cw[CW_DLEN +: LEN_W] >= LEN_W'(DATA_BYTES - 1)) ?
                    IDX_W'(DATA_BYTES - 1) : IDX_W'(cw[CW_DLEN +: LEN_W]);
  assign curLast  = (phase == PH_ADDR) ? addrLast :
                    (phase == PH_DATA) ? dataLast : '0;
  assign isRead   = (phase == PH_DATA) && !cw[CW_WR];
  assign inBus    = (phase != PH_IDLE) && (phase != PH_WAIT);

  always_comb begin
    phNext  = phase;
    lowNext = lowPart;
    tmrNext = tmr;
    idxNext = idx;
    capture = 1'b0;
    if (phase == PH_IDLE) begin
      if (startOk) begin
        phNext  = nextPhase(PH_IDLE, ctrlWord);
        lowNext = 1'b1;
        tmrNext = lowLoad;
        idxNext = '0;
      end
    end else if (phase == PH_WAIT) begin
      if (nandRdy) phNext = PH_IDLE;
    end else if (tmr != '0) begin
      tmrNext = tmr - 1'b1;
    end else if (lowPart) begin
      lowNext = 1'b0;
      tmrNext = highLoad;
      capture = isRead;
    end else if (idx != curLast) begin
      idxNext = idx + 1'b1;
      lowNext = 1'b1;
      tmrNext = lowLoad;
    end else begin
      phNext  = nextPhase(phase, cw);
      idxNext = '0;
      lowNext = 1'b1;
      tmrNext = lowLoad;
    end
    finish = ((phase != PH_IDLE) || startOk) && (phNext == PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      lowPart   <= 1'b0;
      tmr       <= '0;
      idx       <= '0;
      cw        <= '0;
      ceMask    <= '0;
      donePulse <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      phase     <= phNext;
      lowPart   <= lowNext;
      tmr       <= tmrNext;
      idx       <= idxNext;
      donePulse <= finish;
      if (startOk) begin
        cw     <= ctrlWord;
        ceMask <= ctrlWord[CW_CE +: CE_NUM];
      end
      if (finish)       doneFlag <= 1'b1;
      else if (doneClr) doneFlag <= 1'b0;
    end
  end

  assign busy = (phase != PH_IDLE);
  assign ceN  = busy ? ~ceMask : '1;
  assign cle  = (phase == PH_CMD1) || (phase == PH_CMD2PRE) || (phase == PH_CMD2POST);
  assign ale  = (phase == PH_ADDR);
  assign weN  = !(inBus && lowPart && !isRead);
  assign reN  = !(isRead && lowPart);

  always_comb begin
    strb.load    = startOk;
    strb.clrRead = startOk && ctrlWord[CW_RD] && !ctrlWord[CW_WR];
    strb.capture = capture;
    strb.byteIdx = idx;
    unique case (phase)
      PH_CMD1:                 strb.kind = BK_CMD1;
      PH_CMD2PRE, PH_CMD2POST: strb.kind = BK_CMD2;
      PH_ADDR:                 strb.kind = BK_ADDR;
      PH_DATA:                 strb.kind = isRead ? BK_RDATA : BK_WDATA;
      default:                 strb.kind = BK_NONE;
    endcase
  end

endmodule

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [7:0]        opcode1,
  input  logic [7:0]        opcode2,
  input  logic [31:0]       addrLo,
  input  logic [31:0]       addrHi,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        dqIn,
  output logic [7:0]        dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int DATA_BYTES = DATA_W / 8;
  localparam int DB_W       = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [7:0]                  op1Q, op2Q;
  logic [8*ADDR_BYTES_MAX-1:0] addrQ;
  logic [DATA_W-1:0]           wrQ;
  logic [7:0]                  addrBytes [ADDR_BYTES_MAX];
  logic [7:0]                  wrBytes   [DATA_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op1Q  <= '0;
      op2Q  <= '0;
      addrQ <= '0;
      wrQ   <= '0;
    end else if (strb.load) begin
      op1Q  <= opcode1;
      op2Q  <= opcode2;
      addrQ <= {addrHi, addrLo};
      wrQ   <= wrData;
    end
  end

  for (genvar g = 0; g < ADDR_BYTES_MAX; g++) begin : gAddr
    assign addrBytes[g] = addrQ[8*g +: 8];
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : gByte
    assign wrBytes[g] = wrQ[8*g +: 8];
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrRead)
        rdData[8*g +: 8] <= '0;
      else if (strb.capture && (strb.byteIdx == IDX_W'(g)))
        rdData[8*g +: 8] <= dqIn;
    end
  end

  always_comb begin
    unique case (strb.kind)
      BK_CMD1:  dqOut = op1Q;
      BK_CMD2:  dqOut = op2Q;
      BK_ADDR:  dqOut = addrBytes[strb.byteIdx];
      BK_WDATA: dqOut = wrBytes[strb.byteIdx[DB_W-1:0]];
      default:  dqOut = '0;
    endcase
  end

  assign dqOe = (strb.kind == BK_CMD1) || (strb.kind == BK_CMD2) ||
                (strb.kind == BK_ADDR) || (strb.kind == BK_WDATA);

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int TIM_W  = 4,
  parameter int CE_NUM = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic              ctrlWrite,
  input  logic              doneClr,
  input  logic [7:0]        opcode1,
  input  logic [7:0]        opcode2,
  input  logic [31:0]       addrLo,
  input  logic [31:0]       addrHi,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TIM_W-1:0]  tLow,
  input  logic [TIM_W-1:0]  tHigh,
  input  logic [7:0]        nandDqIn,
  input  logic              nandRdy,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              donePulse,
  output logic              doneFlag,
  output logic [CE_NUM-1:0] nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDqOut,
  output logic              nandDqOe
);

  seqStrobe_t strb;

  nand_seq_ctrl #(.TIM_W(TIM_W), .CE_NUM(CE_NUM), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .ctrlWrite(ctrlWrite),
    .doneClr(doneClr), .tLow(tLow), .tHigh(tHigh), .nandRdy(nandRdy),
    .strb(strb), .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN),
    .ceN(nandCeN), .busy(busy), .donePulse(donePulse), .doneFlag(doneFlag)
  );

  nand_seq_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode1(opcode1), .opcode2(opcode2),
    .addrLo(addrLo), .addrHi(addrHi), .wrData(wrData), .dqIn(nandDqIn),
    .dqOut(nandDqOut), .dqOe(nandDqOe), .rdData(rdData)
  );

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
  parameter int CE_NUM = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              donePulse,
  input logic              doneFlag,
  input logic              doneClr,
  input logic [CE_NUM-1:0] nandCeN,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic [7:0]        nandDqOut,
  input logic              nandDqOe
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&nandCeN && nandWeN && nandReN && !nandDqOe));

  a_r4_cle_ale_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  a_r5_dq_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable(nandDqOut));

  a_r5_dq_hold_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> $stable(nandDqOut));

  a_r6_read_undriven: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);

  a_r8_ce_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nandCeN));

  a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> doneFlag);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(doneClr) && !donePulse) |-> !doneFlag);

endmodule

bind nand_op_seq nand_op_seq_chk #(.CE_NUM(CE_NUM)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .donePulse(donePulse),
  .doneFlag(doneFlag), .doneClr(doneClr), .nandCeN(nandCeN),
  .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
  .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe)
);

// File: tb/nand_op_seq_tb_top.sv
`timescale 1ns/1ps
module nand_op_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        ctrlWrite = 1'b0;
  logic        doneClr = 1'b0;
  logic [7:0]  opcode1 = '0, opcode2 = '0;
  logic [31:0] addrLo = '0, addrHi = '0, wrData = '0;
  logic [3:0]  tLow = 4'd1, tHigh = 4'd1;
  logic [7:0]  nandDqIn = '0;
  logic        nandRdy = 1'b1;
  logic [31:0] rdData;
  logic        busy, donePulse, doneFlag;
  logic [7:0]  nandCeN;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDqOut;

  always #4 clk = ~clk;

  nand_op_seq dut_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .ctrlWrite(ctrlWrite),
    .doneClr(doneClr), .opcode1(opcode1), .opcode2(opcode2), .addrLo(addrLo),
    .addrHi(addrHi), .wrData(wrData), .tLow(tLow), .tHigh(tHigh),
    .nandDqIn(nandDqIn), .nandRdy(nandRdy), .rdData(rdData), .busy(busy),
    .donePulse(donePulse), .doneFlag(doneFlag), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe)
  );

  typedef struct {
    byte        kind;
    logic [7:0] val;
    int         lowW;
    logic [7:0] ce;
  } busEv_t;

  busEv_t     expQ[$];
  int         nChecks = 0;
  int         nErrors = 0;
  logic [7:0] rdBuf [4];
  int         rdIdx = 0;
  int         lowCnt = 0;
  byte        curK;
  logic [7:0] curDq, curCe;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic string kindReq(input byte k);
    if (k == "C") return "R4";
    if (k == "A") return "R3";
    if (k == "W") return "R5";
    return "R6";
  endfunction

  // device model and bus monitor
  always @(negedge clk) begin
    if (!rstN) begin
      lowCnt = 0;
      rdIdx  = 0;
    end else begin
      if (!nandReN) nandDqIn = rdBuf[rdIdx];
      if (!nandWeN) begin
        lowCnt++;
        curDq = nandDqOut;
        curK  = nandCle ? "C" : (nandAle ? "A" : "W");
        curCe = nandCeN;
      end else if (!nandReN) begin
        lowCnt++;
        curDq = nandDqIn;
        curK  = "R";
        curCe = nandCeN;
      end else if (lowCnt > 0) begin
        if (curK == "R") rdIdx = (rdIdx + 1) % 4;
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected strobe", {56'd0, curDq}, 64'd0);
        end else begin
          busEv_t e;
          e = expQ.pop_front();
          chk(e.kind == curK, "R2", "cycle kind order", 64'(curK), 64'(e.kind));
          chk(e.val == curDq, kindReq(e.kind), "bus byte", {56'd0, curDq}, {56'd0, e.val});
          chk(e.lowW == lowCnt, "R11", "strobe low width", 64'(lowCnt), 64'(e.lowW));
          chk(e.ce == curCe, "R8", "chip enables", {56'd0, curCe}, {56'd0, e.ce});
        end
        lowCnt = 0;
      end
    end
  end

  task automatic push(input byte k, input logic [7:0] v, input int lw, input logic [7:0] ce);
    busEv_t e;
    e.kind = k; e.val = v; e.lowW = lw; e.ce = ce;
    expQ.push_back(e);
  endtask

  task automatic runOp(input logic [31:0] cw, input logic [7:0] o1, input logic [7:0] o2,
                       input logic [31:0] aLo, input logic [31:0] aHi,
                       input logic [31:0] wd, input logic [31:0] rdWord,
                       input int tl, input int th, input int injectAt, input int rdyAt);
    int lw, na, nd, cyc;
    logic [7:0]  ce;
    logic [31:0] mask;
    lw = (tl == 0) ? 1 : tl;
    ce = ~cw[15:8];
    na = (int'(cw[3:0]) + 1 > 8) ? 8 : int'(cw[3:0]) + 1;
    nd = (int'(cw[23:20]) + 1 > 4) ? 4 : int'(cw[23:20]) + 1;
    if (cw[30]) push("C", o1, lw, ce);
    if (cw[29])
      for (int i = 0; i < na; i++)
        push("A", (i < 4) ? aLo[8*i +: 8] : aHi[8*(i-4) +: 8], lw, ce);
    if (cw[25] && !cw[24]) push("C", o2, lw, ce);
    if (cw[27]) begin
      for (int i = 0; i < nd; i++) push("W", wd[8*i +: 8], lw, ce);
    end else if (cw[26]) begin
      for (int i = 0; i < nd; i++) push("R", rdWord[8*i +: 8], lw, ce);
    end
    if (cw[25] && cw[24]) push("C", o2, lw, ce);
    for (int i = 0; i < 4; i++) rdBuf[i] = rdWord[8*i +: 8];

    @(negedge clk);
    ctrlWord = cw; opcode1 = o1; opcode2 = o2; addrLo = aLo; addrHi = aHi;
    wrData = wd; tLow = 4'(tl); tHigh = 4'(th); rdIdx = 0;
    if (cw[16]) nandRdy = 1'b0;
    ctrlWrite = 1'b1;
    @(negedge clk);
    ctrlWrite = 1'b0;
    cyc = 0;
    while (!donePulse && cyc < 5000) begin
      cyc++;
      if (cyc == injectAt) begin
        ctrlWord  = 32'hC000_8000;
        opcode1   = ~o1;
        addrLo    = ~aLo;
        ctrlWrite = 1'b1;
      end else begin
        ctrlWrite = 1'b0;
      end
      if (cw[16] && cyc == rdyAt) nandRdy = 1'b1;
      @(negedge clk);
    end
    ctrlWrite = 1'b0;
    chk(donePulse, "R9", "done pulse seen", 64'(donePulse), 64'd1);
    chk(doneFlag, "R9", "done flag set", 64'(doneFlag), 64'd1);
    if (cw[16]) chk(cyc == rdyAt, "R7", "completion edge vs ready", 64'(cyc), 64'(rdyAt));
    @(negedge clk);
    chk(!donePulse, "R9", "pulse one clock", 64'(donePulse), 64'd0);
    chk(!busy && nandCeN == 8'hFF, "R8", "ce released when idle", {56'd0, nandCeN}, 64'hFF);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2", "expected cycles left", 64'(expQ.size()), 64'd0);
    expQ.delete();
    if (!cw[27] && cw[26]) begin
      mask = (nd == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nd)) - 1);
      chk(rdData == (rdWord & mask), "R6", "read word", {32'd0, rdData}, {32'd0, rdWord & mask});
    end
    nandRdy = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nandCeN == 8'hFF && nandWeN && nandReN && !nandCle && !nandAle &&
        !nandDqOe && !busy && !doneFlag, "R1", "reset state",
        {48'd0, nandCeN, 7'd0, busy, doneFlag, nandDqOe}, 64'hFF00);

    // R2 R3 R4 R6 R7: page-read style, second command early, ready wait, ce 2
    runOp(32'hE631_0404, 8'h00, 8'h30, 32'h4433_2211, 32'h0000_00A5,
          32'h0, 32'hDEAD_BEEF, 2, 1, 0, 300);
    // R5 R4: program style, second command late, ce 0
    runOp(32'hEB20_0101, 8'h80, 8'h10, 32'h0000_3C5A, 32'h0,
          32'h00C3_B2A1, 32'h0, 1, 2, 0, 0);
    // R6 R11: single read byte, zero widths act as one, upper bytes clear, ce 7
    runOp(32'hC400_8000, 8'h70, 8'h00, 32'h0, 32'h0,
          32'h0, 32'h0000_00E1, 0, 0, 0, 0);
    // R3: length field 15 limited to 8 address bytes, ce 1
    runOp(32'hA000_020F, 8'h00, 8'h00, 32'h8765_4321, 32'h0FED_CBA9,
          32'h0, 32'h0, 3, 1, 0, 0);
    // R5: data length field 15 limited to 4 bytes, ce 3
    runOp(32'h88F0_0800, 8'h00, 8'h00, 32'h0, 32'h0,
          32'h1122_3344, 32'h0, 1, 1, 0, 0);
    // R10: control write during a running operation is ignored
    runOp(32'hEB20_0101, 8'h85, 8'h11, 32'h0000_7E01, 32'h0,
          32'h0066_5544, 32'h0, 2, 2, 5, 0);
    // R2 R9: empty operation completes at once
    runOp(32'h8000_0000, 8'h00, 8'h00, 32'h0, 32'h0, 32'h0, 32'h0, 1, 1, 0, 0);
    // R7: ready wait alone
    runOp(32'h8001_0100, 8'h00, 8'h00, 32'h0, 32'h0, 32'h0, 32'h0, 1, 1, 0, 20);

    // R9: doneClr clears the sticky flag
    @(negedge clk);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk(!doneFlag, "R9", "flag cleared", 64'(doneFlag), 64'd0);

    // R10: a control write without bit 31 has no effect
    @(negedge clk);
    ctrlWord = 32'h4000_0100;
    ctrlWrite = 1'b1;
    @(negedge clk);
    ctrlWrite = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && !doneFlag && nandCeN == 8'hFF, "R10", "no start without go bit",
        {56'd0, busy, doneFlag, 6'd0}, 64'd0);
    chk(expQ.size() == 0, "R10", "no strobes without go bit", 64'(expQ.size()), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule